// File: doc/BRIEF.md
# SECDED-Protected SRAM with Raw Debug Access

This block wraps a word-organised SRAM with single-error-correct, double-error-detect protection. Each word written by the CPU port is stored beside six check bits derived from it. Each CPU read decodes the stored word. A single flipped bit is corrected on the way out, and a word with two flipped bits is passed through unchanged and flagged. Single-bit errors set a sticky flag and can raise an interrupt under an enable bit. Double-bit errors raise an exception line that no setting can hold back. An optional repair function writes a corrected word back into the array.

A small register window holds a 24-bit word pointer, split into three byte registers, together with a raw data register, a raw check-bits register and a command register. While the privileged-mode input is high, commands can copy the raw registers into the pointed word without encoding, or copy the pointed word out without decoding. Faults can be planted in this way to test error handlers. While the input is low, commands have no effect.

Top module: `ecc_sram_guard`

## Requirements
- R1: A CPU write (cpu_req=1, cpu_we=1) stores cpu_wdata with 6 check bits. Data bits 0..15 take codeword positions 3,5,6,7,9..15,17..21 in increasing order. Check bit k (k=0..4) is the even parity of the data bits whose position has bit k set. Check bit 5 is the parity of all 16 data bits and check bits 0..4.
- R2: A CPU read request (cpu_req=1, cpu_we=0) raises cpu_rvalid in the next cycle, with cpu_rdata holding the decoded word. For an intact word or a single-bit error, that word is the original data.
- R3: reg_addr 0/1/2 hold pointer bits 23:16, 15:8 and 7:0, taken from reg_wdata[7:0]. The word index is the low ADDR_W pointer bits. A command is ignored while any higher pointer bit is set.
- R4: Writing 0x0082 to reg_addr 5 stores the raw data register (reg_addr 3) and the raw check register (reg_addr 4, bits 5:0) into the pointed word with no encoding. It also clears the repair enable, CTRL (reg_addr 6) bit 1.
- R5: Writing 0x0081 to reg_addr 5 loads the pointed word's stored data and check bits into the raw data and raw check registers. No flag, interrupt or exception results.
- R6: Command writes have an effect only while special_mode is 1. Otherwise the array, the raw registers and CTRL stay unchanged.
- R7: The error flags change at the clock edge after the one in which cpu_rvalid is high.
- R8: A single-bit error sets STATUS (reg_addr 7) bit 0. sb_irq is high while that bit and CTRL bit 0 are both set.
- R9: A double-bit error sets STATUS bit 1 and raises db_exc regardless of CTRL. cpu_rdata returns the stored data unchanged, and the word is never written back.
- R10: If CTRL bit 1 is set (its reset value), a single-bit error found by a read causes the corrected data and fresh check bits to be written back at the following edge.
- R11: Flags are cleared by writing 1 to their STATUS bit, and a new error in the same cycle wins over the clear. err_addr latches the word index of an error found while both flags are clear.
- R12: reg_addr 5 always reads 0. The raw data and raw check registers keep their values until a command or a direct register write changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | Privileged debug mode; enables raw commands |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | ADDR_W | CPU word index |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Decoded read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the request |
| reg_wr | input | 1 | Register window write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write value |
| reg_rdata | output | DATA_W | Register read value for reg_addr |
| sb_irq | output | 1 | Maskable single-bit error interrupt |
| db_exc | output | 1 | Unmaskable double-bit error exception |
| err_addr | output | ADDR_W | Word index of the first recorded error |

## Verification
Clean words are tried with all-zero, all-one, alternating and sparse patterns. These separate a correct check-bit encoding from a swapped or shifted mask, which the raw read-back exposes bit by bit. Planted faults are placed in a low data bit, the top data bit and the overall parity bit, and each is told apart from a double flip by which flag rises and whether the read data is repaired. Repair is tried both off, as the raw write leaves it, and on, and the raw read-back shows whether the array was changed. Commands sent outside privileged mode and commands with an out-of-range pointer show at the ports that nothing moved.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_SINGLE = 2'd1,
      ERR_DOUBLE = 2'd2
   } err_kind_t;

   typedef enum logic [2:0] {
      RS_PTR_HI  = 3'd0,
      RS_PTR_MID = 3'd1,
      RS_PTR_LO  = 3'd2,
      RS_RAW_DAT = 3'd3,
      RS_RAW_CHK = 3'd4,
      RS_CMD     = 3'd5,
      RS_CTRL    = 3'd6,
      RS_STATUS  = 3'd7
   } reg_sel_t;

   localparam logic [7:0] CMD_RAW_RD = 8'h81;
   localparam logic [7:0] CMD_RAW_WR = 8'h82;

   // codeword position of data bit d: skip the power-of-two slots
   function automatic int data_pos(int d, int hw);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 1; p < (1 << hw); p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == d) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   // data bits covered by Hamming check bit k
   function automatic logic [63:0] cover_mask(int k, int dw, int hw);
      logic [63:0] m;
      m = '0;
      for (int d = 0; d < dw; d++) begin
         if (((data_pos(d, hw) >> k) & 1) == 1) m[d] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5
) (
   input  logic [DATA_W-1:0] data,
   output logic [HAM_W:0]    chk
);
   logic [HAM_W-1:0] ham;

   for (genvar k = 0; k < HAM_W; k++) begin : g_ham
      localparam logic [63:0] MASK = cover_mask(k, DATA_W, HAM_W);
      assign ham[k] = ^(data & MASK[DATA_W-1:0]);
   end

   assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5
) (
   input  logic [DATA_W-1:0] data,
   input  logic [HAM_W:0]    chk,
   output logic [DATA_W-1:0] fixed,
   output err_kind_t         kind
);
   logic [HAM_W-1:0]  syn;
   logic              odd;
   logic [DATA_W-1:0] flip;

   for (genvar k = 0; k < HAM_W; k++) begin : g_syn
      localparam logic [63:0] MASK = cover_mask(k, DATA_W, HAM_W);
      assign syn[k] = (^(data & MASK[DATA_W-1:0])) ^ chk[k];
   end

   assign odd = (^data) ^ (^chk);

   for (genvar d = 0; d < DATA_W; d++) begin : g_fix
      localparam int POS = data_pos(d, HAM_W);
      assign flip[d] = odd && (syn == HAM_W'(POS));
   end

   assign fixed = data ^ flip;

   always_comb begin
      if (odd)             kind = ERR_SINGLE;
      else if (syn != '0)  kind = ERR_DOUBLE;
      else                 kind = ERR_NONE;
   end
endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
   parameter int WORD_W = 22,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wword,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rword,
   input  logic [ADDR_W-1:0] paddr,
   output logic [WORD_W-1:0] pword
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword;
      if (re) rword <= mem[raddr];
   end

   assign pword = mem[paddr];
endmodule

// File: rtl/ecc_sram_guard.sv
module ecc_sram_guard
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rvalid,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sb_irq,
   output logic              db_exc,
   output logic [ADDR_W-1:0] err_addr
);
   localparam int CHK_W  = HAM_W + 1;
   localparam int WORD_W = DATA_W + CHK_W;
   localparam int PTR_W  = 24;

   if (DATA_W < 8 || DATA_W < CHK_W) begin : g_bad_dw
      $error("DATA_W must hold a pointer byte and the check field");
   end
   if (DATA_W > (1 << HAM_W) - HAM_W - 1) begin : g_bad_hw
      $error("HAM_W too small for DATA_W");
   end
   if (ADDR_W < 1 || ADDR_W >= PTR_W) begin : g_bad_aw
      $error("ADDR_W must be below the pointer width");
   end

   // register window state
   logic [PTR_W-1:0]  ptr_q;
   logic [DATA_W-1:0] raw_dat_q;
   logic [CHK_W-1:0]  raw_chk_q;
   logic              sb_ie_q, repair_q;
   logic              sts_sb_q, sts_db_q;
   logic [ADDR_W-1:0] err_addr_q;
   logic              rvalid_q;
   logic [ADDR_W-1:0] rd_addr_q;

   // datapath
   logic [CHK_W-1:0]  enc_wr, enc_wb;
   logic [WORD_W-1:0] rd_word, peek_word;
   logic [DATA_W-1:0] dec_data;
   err_kind_t         dec_kind;
   logic              st_we;
   logic [ADDR_W-1:0] st_waddr;
   logic [WORD_W-1:0] st_wword;

   logic              ptr_ok, cmd_ok, raw_wr, raw_rd, cpu_wr, wb_we;
   logic              set_sb, set_db, clr_sb, clr_db;
   logic [ADDR_W-1:0] ptr_idx;

   assign ptr_idx = ptr_q[ADDR_W-1:0];
   assign ptr_ok  = (ptr_q[PTR_W-1:ADDR_W] == '0);
   assign cmd_ok  = reg_wr && (reg_addr == RS_CMD) && special_mode && ptr_ok;
   assign raw_wr  = cmd_ok && (reg_wdata == DATA_W'(CMD_RAW_WR));
   assign raw_rd  = cmd_ok && (reg_wdata == DATA_W'(CMD_RAW_RD));
   assign cpu_wr  = cpu_req && cpu_we;

   ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc_wr (
      .data(cpu_wdata), .chk(enc_wr));

   ecc_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
      .data(rd_word[WORD_W-1:CHK_W]), .chk(rd_word[CHK_W-1:0]),
      .fixed(dec_data), .kind(dec_kind));

   ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc_wb (
      .data(dec_data), .chk(enc_wb));

   // write-back only when no other write owns the port this cycle
   assign wb_we = rvalid_q && (dec_kind == ERR_SINGLE) && repair_q && !raw_wr && !cpu_wr;

   always_comb begin
      st_we    = 1'b1;
      st_waddr = rd_addr_q;
      st_wword = {dec_data, enc_wb};
      if (raw_wr) begin
         st_waddr = ptr_idx;
         st_wword = {raw_dat_q, raw_chk_q};
      end else if (cpu_wr) begin
         st_waddr = cpu_addr;
         st_wword = {cpu_wdata, enc_wr};
      end else if (!wb_we) begin
         st_we = 1'b0;
      end
   end

   ecc_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .we(st_we), .waddr(st_waddr), .wword(st_wword),
      .re(cpu_req && !cpu_we), .raddr(cpu_addr), .rword(rd_word),
      .paddr(ptr_idx), .pword(peek_word));

   assign set_sb = rvalid_q && (dec_kind == ERR_SINGLE);
   assign set_db = rvalid_q && (dec_kind == ERR_DOUBLE);
   assign clr_sb = reg_wr && (reg_addr == RS_STATUS) && reg_wdata[0];
   assign clr_db = reg_wr && (reg_addr == RS_STATUS) && reg_wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         raw_dat_q  <= '0;
         raw_chk_q  <= '0;
         sb_ie_q    <= 1'b0;
         repair_q   <= 1'b1;
         sts_sb_q   <= 1'b0;
         sts_db_q   <= 1'b0;
         err_addr_q <= '0;
         rvalid_q   <= 1'b0;
         rd_addr_q  <= '0;
      end else begin
         rvalid_q <= cpu_req && !cpu_we;
         if (cpu_req && !cpu_we) rd_addr_q <= cpu_addr;

         if (reg_wr) begin
            case (reg_sel_t'(reg_addr))
               RS_PTR_HI:  ptr_q[23:16] <= reg_wdata[7:0];
               RS_PTR_MID: ptr_q[15:8]  <= reg_wdata[7:0];
               RS_PTR_LO:  ptr_q[7:0]   <= reg_wdata[7:0];
               RS_RAW_DAT: raw_dat_q    <= reg_wdata;
               RS_RAW_CHK: raw_chk_q    <= reg_wdata[CHK_W-1:0];
               RS_CTRL: begin
                  sb_ie_q  <= reg_wdata[0];
                  repair_q <= reg_wdata[1];
               end
               default: ;
            endcase
         end

         if (raw_wr) repair_q <= 1'b0;
         if (raw_rd) begin
            raw_dat_q <= peek_word[WORD_W-1:CHK_W];
            raw_chk_q <= peek_word[CHK_W-1:0];
         end

         sts_sb_q <= set_sb || (sts_sb_q && !clr_sb);
         sts_db_q <= set_db || (sts_db_q && !clr_db);
         if ((set_sb || set_db) && !sts_sb_q && !sts_db_q) err_addr_q <= rd_addr_q;
      end
   end

   always_comb begin
      case (reg_sel_t'(reg_addr))
         RS_PTR_HI:  reg_rdata = DATA_W'(ptr_q[23:16]);
         RS_PTR_MID: reg_rdata = DATA_W'(ptr_q[15:8]);
         RS_PTR_LO:  reg_rdata = DATA_W'(ptr_q[7:0]);
         RS_RAW_DAT: reg_rdata = raw_dat_q;
         RS_RAW_CHK: reg_rdata = DATA_W'(raw_chk_q);
         RS_CTRL:    reg_rdata = DATA_W'({repair_q, sb_ie_q});
         RS_STATUS:  reg_rdata = DATA_W'({sts_db_q, sts_sb_q});
         default:    reg_rdata = '0;
      endcase
   end

   assign cpu_rdata  = dec_data;
   assign cpu_rvalid = rvalid_q;
   assign sb_irq     = sts_sb_q && sb_ie_q;
   assign db_exc     = sts_db_q;
   assign err_addr   = err_addr_q;
endmodule

// File: rtl/ecc_sram_guard_chk.sv
module ecc_sram_guard_chk
   import ecc_sram_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              special_mode,
   input logic              reg_wr,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              cpu_rvalid,
   input err_kind_t         dec_kind,
   input logic              wb_we,
   input logic              sb_ie_q,
   input logic              sts_sb_q,
   input logic              sts_db_q,
   input logic [DATA_W-1:0] raw_dat_q,
   input logic [HAM_W:0]    raw_chk_q,
   input logic              sb_irq,
   input logic              db_exc,
   input logic [ADDR_W-1:0] err_addr
);
   a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && reg_wr && reg_addr == RS_CMD) |=> ($stable(raw_dat_q) && $stable(raw_chk_q)));

   a_r7_single_flag_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && dec_kind == ERR_SINGLE) |=> sts_sb_q);

   a_r9_double_exc: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && dec_kind == ERR_DOUBLE) |=> db_exc);

   a_r9_no_double_repair: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_kind == ERR_DOUBLE) |-> !wb_we);

   a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sb_irq) |-> sb_ie_q);

   a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts_sb_q || sts_db_q) && !(reg_wr && reg_addr == RS_STATUS)) |=> $stable(err_addr));

   a_r12_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RS_CMD) |-> (reg_rdata == '0));
endmodule

bind ecc_sram_guard ecc_sram_guard_chk #(.DATA_W(DATA_W), .HAM_W(HAM_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cpu_rvalid(cpu_rvalid),
   .dec_kind(dec_kind), .wb_we(wb_we), .sb_ie_q(sb_ie_q), .sts_sb_q(sts_sb_q),
   .sts_db_q(sts_db_q), .raw_dat_q(raw_dat_q), .raw_chk_q(raw_chk_q),
   .sb_irq(sb_irq), .db_exc(db_exc), .err_addr(err_addr));

// File: tb/ecc_sram_guard_bench.sv
`timescale 1ns/1ps
module ecc_sram_guard_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        special_mode = 1'b1;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_rvalid;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sb_irq, db_exc;
   logic [7:0]  err_addr;

   int total = 0;
   int bad   = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   ecc_sram_guard u_ecc_sram_guard (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sb_irq(sb_irq), .db_exc(db_exc), .err_addr(err_addr));

   // stimulus table: {word index, data}
   localparam logic [23:0] VEC [8] = '{
      {8'h10, 16'h5AA5}, {8'h11, 16'hFFFF}, {8'h12, 16'h1234}, {8'h13, 16'h8001},
      {8'h14, 16'h0000}, {8'h00, 16'hA5A5}, {8'hFF, 16'h00F0}, {8'h7E, 16'h4000}};

   // check bits as the R1 encoding defines them
   function automatic logic [5:0] ref_chk(logic [15:0] d);
      logic [21:0] cw;
      logic [5:0]  c;
      int di;
      cw = '0;
      c  = '0;
      di = 0;
      for (int p = 1; p <= 21; p++) begin
         if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
            cw[p] = d[di];
            di++;
         end
      end
      for (int k = 0; k < 5; k++) begin
         for (int p = 1; p <= 21; p++) if ((p >> k) % 2 == 1) c[k] = c[k] ^ cw[p];
      end
      c[5] = (^d) ^ (^c[4:0]);
      return c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   task automatic reg_write(logic [2:0] a, logic [15:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [2:0] a, output logic [15:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic cpu_write(logic [7:0] a, logic [15:0] d);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      tick();
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_read(logic [7:0] a, output logic [15:0] d);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
      tick();
      cpu_req = 1'b0;
      check("R2 rvalid", 32'(cpu_rvalid), 32'd1);
      d = cpu_rdata;
   endtask

   task automatic set_ptr(logic [7:0] hi, logic [7:0] lo);
      reg_write(3'd0, {8'h00, hi});
      reg_write(3'd1, 16'h0000);
      reg_write(3'd2, {8'h00, lo});
   endtask

   task automatic raw_read(logic [7:0] a, output logic [15:0] d, output logic [15:0] c);
      set_ptr(8'h00, a);
      reg_write(3'd5, 16'h0081);
      reg_read(3'd3, d);
      reg_read(3'd4, c);
   endtask

   task automatic plant(logic [7:0] a, logic [15:0] d, logic [5:0] c);
      reg_write(3'd3, d);
      reg_write(3'd4, {10'h0, c});
      set_ptr(8'h00, a);
      reg_write(3'd5, 16'h0082);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, d, c;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      check("R8 reset sb_irq", 32'(sb_irq), 0);
      check("R9 reset db_exc", 32'(db_exc), 0);
      check("R2 reset rvalid", 32'(cpu_rvalid), 0);
      reg_read(3'd7, v); check("R11 reset status", 32'(v), 0);
      reg_read(3'd6, v); check("R10 reset ctrl repair on", 32'(v), 32'h2);
      reg_read(3'd5, v); check("R12 cmd reads zero", 32'(v), 0);

      // table walk: clean words, encoding and raw read-back
      foreach (VEC[i]) begin
         cpu_write(VEC[i][23:16], VEC[i][15:0]);
         cpu_read(VEC[i][23:16], d);
         check("R2 clean read data", 32'(d), 32'(VEC[i][15:0]));
         tick();
         reg_read(3'd7, v); check("R7 clean read no flag", 32'(v), 0);
         raw_read(VEC[i][23:16], d, c);
         check("R5 raw data", 32'(d), 32'(VEC[i][15:0]));
         check("R1 stored check bits", 32'(c), 32'(ref_chk(VEC[i][15:0])));
         reg_read(3'd7, v); check("R5 raw read no flag", 32'(v), 0);
      end

      // normal mode: commands ignored
      special_mode = 1'b0;
      plant(8'h10, 16'h1111, 6'h00);
      reg_read(3'd6, v); check("R6 ctrl untouched", 32'(v), 32'h2);
      cpu_read(8'h10, d);
      check("R6 array untouched", 32'(d), 32'h5AA5);
      tick();
      reg_read(3'd7, v); check("R6 no flag", 32'(v), 0);
      reg_write(3'd5, 16'h0081);
      reg_read(3'd3, v); check("R6 raw read ignored", 32'(v), 32'h1111);
      special_mode = 1'b1;

      // single-bit error, repair off after raw write
      plant(8'h10, 16'h5AAD, ref_chk(16'h5AA5));
      reg_read(3'd6, v); check("R4 raw write clears repair", 32'(v), 0);
      cpu_read(8'h10, d);
      check("R8 corrected data", 32'(d), 32'h5AA5);
      reg_read(3'd7, v); check("R7 flag not yet", 32'(v), 0);
      tick();
      reg_read(3'd7, v); check("R7 flag one cycle later", 32'(v), 32'h1);
      check("R8 irq masked", 32'(sb_irq), 0);
      check("R11 err_addr", 32'(err_addr), 32'h10);
      raw_read(8'h10, d, c);
      check("R4 no repair when off", 32'(d), 32'h5AAD);
      reg_write(3'd6, 16'h0003);
      check("R8 irq enabled", 32'(sb_irq), 1);
      reg_write(3'd7, 16'h0001);
      check("R11 clear irq", 32'(sb_irq), 0);
      reg_read(3'd7, v); check("R11 cleared status", 32'(v), 0);

      // repair on
      cpu_read(8'h10, d);
      tick();
      check("R8 irq raised", 32'(sb_irq), 1);
      raw_read(8'h10, d, c);
      check("R10 repaired data", 32'(d), 32'h5AA5);
      check("R10 repaired check bits", 32'(c), 32'(ref_chk(16'h5AA5)));
      reg_write(3'd7, 16'h0003);

      // overall parity bit flipped
      plant(8'h11, 16'hFFFF, ref_chk(16'hFFFF) ^ 6'h20);
      reg_write(3'd6, 16'h0003);
      cpu_read(8'h11, d);
      check("R8 parity-bit error data", 32'(d), 32'hFFFF);
      tick();
      reg_read(3'd7, v); check("R8 parity-bit error flag", 32'(v), 32'h1);
      reg_write(3'd7, 16'h0003);

      // double-bit error
      plant(8'h12, 16'h1237, ref_chk(16'h1234));
      reg_write(3'd6, 16'h0002);
      raw_read(8'h12, d, c);
      reg_read(3'd7, v); check("R5 planted raw read no flag", 32'(v), 0);
      check("R5 no exception on raw read", 32'(db_exc), 0);
      cpu_read(8'h12, d);
      check("R9 data not corrected", 32'(d), 32'h1237);
      tick();
      check("R9 exception", 32'(db_exc), 1);
      reg_read(3'd7, v); check("R9 status", 32'(v), 32'h2);
      raw_read(8'h12, d, c);
      check("R9 never repaired", 32'(d), 32'h1237);
      reg_write(3'd6, 16'h0000);
      check("R9 unmaskable", 32'(db_exc), 1);
      reg_write(3'd7, 16'h0002);
      check("R11 clear exception", 32'(db_exc), 0);

      // first error address held
      plant(8'h13, 16'h8000, ref_chk(16'h8001));
      plant(8'h14, 16'h8000, ref_chk(16'h0000));
      cpu_read(8'h13, d);
      tick();
      cpu_read(8'h14, d);
      tick();
      check("R11 first address kept", 32'(err_addr), 32'h13);
      reg_read(3'd7, v); check("R11 sticky", 32'(v), 32'h1);
      reg_write(3'd7, 16'h0001);

      // pointer out of range
      reg_write(3'd3, 16'hBEEF);
      set_ptr(8'h01, 8'h10);
      reg_write(3'd5, 16'h0081);
      reg_read(3'd3, v); check("R3 out-of-range ignored", 32'(v), 32'hBEEF);
      reg_read(3'd0, v); check("R3 pointer high byte", 32'(v), 32'h01);
      reg_read(3'd5, v); check("R12 cmd zero after command", 32'(v), 0);
      tick();
      reg_read(3'd3, v); check("R12 raw data held", 32'(v), 32'hBEEF);

      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule